// File: doc/BRIEF.md
# Auto-Acknowledge Receive Frame Filter

This block sits behind a receive frame parser. It waits for the strobe that marks the last symbol of an incoming IEEE 802.15.4 frame. At that strobe it takes the parser's verdicts: PHR validity, the 3-bit frame type, the ack-request bit, the address-match result and the FCS result. From these it decides whether to raise a receive-complete pulse, whether to raise an address-match interrupt pulse, and whether an acknowledgment is due. A CRC-valid flag keeps the FCS result of the most recent frame until the next strobe.

When an acknowledgment is due, a turnaround counter counts symbol ticks and emits a one-cycle ack-start pulse after the selected number of symbol periods. The long turnaround is 12 symbols and the short one is 2 symbols. Frame types 100 to 111 are reserved, and two configuration bits decide whether such frames are dropped, reported on FCS alone, or handled as data frames. Promiscuous mode reports every frame whose PHR is valid, but it acknowledges only frames that pass the filter. The disable-ack bit suppresses every acknowledgment. All configuration bits are captured at the end-of-frame strobe.

Top module: `rxack_filter_top`

## Requirements
- R1: A reserved-type frame (type bit 2 = 1) with the upload bit clear raises no receive-complete pulse, no address interrupt and no acknowledgment, unless promiscuous mode is on.
- R2: A reserved-type frame with the upload bit set and the filter bit clear raises the receive-complete pulse exactly when its FCS is valid. It never raises the address interrupt and never gets an acknowledgment.
- R3: A reserved-type frame with both the upload and filter bits set is handled as a data frame. It raises the address interrupt on an address match, and it is acknowledged when it matches, has a valid FCS and requests an acknowledgment.
- R4: For a non-reserved type with a valid PHR, the address interrupt pulses on an address match and the receive-complete pulse fires on an address match with a valid FCS. Both pulses last one cycle and appear in the cycle after the strobe.
- R5: Among non-reserved types, only data (001) and MAC command (011) can be acknowledged. The frame also needs an address match, a valid FCS and the ack-request bit.
- R6: With the short-ack bit clear, ack-start pulses for one cycle in the cycle after the 12th symbol tick that follows the strobe. A tick in the strobe cycle is not counted.
- R7: With the short-ack bit set, ack-start follows the 2nd symbol tick instead.
- R8: In promiscuous mode, every frame with a valid PHR raises the receive-complete pulse, whatever its filter and FCS results.
- R9: At each strobe the CRC-valid flag takes the value (PHR valid AND FCS valid) in the next cycle, and it holds between strobes.
- R10: With the disable-ack bit set, no ack-start pulse is produced.
- R11: A strobe that arrives while an acknowledgment is pending cancels it. Only the new frame's decision applies.
- R12: Configuration bits are captured at the strobe. Changing them afterwards does not change that frame's outcome or its turnaround.
- R13: Reset clears all pulses, the counter and the CRC-valid flag. A frame with an invalid PHR raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_tick | input | 1 | One-cycle pulse per symbol period |
| eof_strobe | input | 1 | Last symbol of a frame received |
| phr_ok | input | 1 | PHR of the frame was valid |
| frame_type | input | 3 | Frame type field |
| ack_req | input | 1 | Frame requests an acknowledgment |
| addr_hit | input | 1 | Frame passed the address filter |
| fcs_ok | input | 1 | FCS check passed |
| cfg_filt_rsv | input | 1 | Apply address filtering to reserved types |
| cfg_upld_rsv | input | 1 | Process reserved types further |
| cfg_short_ack | input | 1 | Use the 2-symbol turnaround |
| cfg_promisc | input | 1 | Promiscuous mode |
| cfg_no_ack | input | 1 | Never acknowledge |
| rx_end_pulse | output | 1 | Receive-complete pulse |
| addr_irq_pulse | output | 1 | Address-match interrupt pulse |
| crc_ok_flag | output | 1 | FCS result of the last frame |
| ack_start_pulse | output | 1 | Start of acknowledgment transmission |

## Verification
A wrong frame classification shows at the ports in the cycle after the strobe, as a missing or extra receive-complete or address pulse. A wrong turnaround counter or captured configuration shows later, up to 12 symbol ticks on, as an ack-start pulse that is early, late, missing or repeated. The bench therefore records the expected outcome of each frame, counts symbol ticks from the strobe itself, and closes every frame's acknowledgment window when the next strobe arrives. Each frame is followed by a change in configuration, and some frames are cut short by the next strobe, so that capture errors and cancellation errors both become visible.

// File: rtl/rxack_pkg.sv
package rxack_pkg;
  localparam int FT_W = 3;

  localparam logic [FT_W-1:0] FT_DATA = 3'b001;
  localparam logic [FT_W-1:0] FT_CMD  = 3'b011;

  typedef enum logic [1:0] {
    CL_PLAIN   = 2'd0,
    CL_ACKABLE = 2'd1,
    CL_RSV_DROP = 2'd2,
    CL_RSV_FCS = 2'd3
  } frm_class_e;

  typedef struct packed {
    logic rx_end;
    logic addr_irq;
    logic crc_ok;
    logic ack_go;
  } verdict_t;
endpackage

// File: rtl/rxack_class.sv
module rxack_class
  import rxack_pkg::*;
#(
  parameter int TYPE_W = FT_W
) (
  input  logic [TYPE_W-1:0] frame_type,
  input  logic              filt_rsv,
  input  logic              upld_rsv,
  output frm_class_e        cls
);
  logic is_rsv;
  assign is_rsv = frame_type[TYPE_W-1];

  always_comb begin
    cls = CL_PLAIN;
    if (is_rsv) begin
      if (!upld_rsv)     cls = CL_RSV_DROP;
      else if (filt_rsv) cls = CL_ACKABLE;
      else               cls = CL_RSV_FCS;
    end else if (frame_type == FT_DATA || frame_type == FT_CMD) begin
      cls = CL_ACKABLE;
    end
  end
endmodule

// File: rtl/rxack_verdict.sv
module rxack_verdict
  import rxack_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       eof_strobe,
  input  logic       phr_ok,
  input  logic       ack_req,
  input  logic       addr_hit,
  input  logic       fcs_ok,
  input  frm_class_e cls,
  input  logic       promisc,
  input  logic       no_ack,
  output logic       rx_end_pulse,
  output logic       addr_irq_pulse,
  output logic       crc_ok_flag,
  output logic       ack_go
);
  verdict_t v;
  logic filtered;

  always_comb begin
    v = '0;
    filtered = 1'b0;
    if (phr_ok) begin
      v.crc_ok = fcs_ok;
      unique case (cls)
        CL_PLAIN, CL_ACKABLE: begin
          filtered   = addr_hit;
          v.addr_irq = addr_hit;
          v.rx_end   = addr_hit & fcs_ok;
          v.ack_go   = (cls == CL_ACKABLE) & addr_hit & fcs_ok & ack_req & ~no_ack;
        end
        CL_RSV_FCS:  v.rx_end = fcs_ok;
        CL_RSV_DROP: v.rx_end = 1'b0;
        default:     v.rx_end = 1'b0;
      endcase
      if (promisc) v.rx_end = 1'b1;
    end
  end

  assign ack_go = eof_strobe & v.ack_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_end_pulse   <= 1'b0;
      addr_irq_pulse <= 1'b0;
      crc_ok_flag    <= 1'b0;
    end else begin
      rx_end_pulse   <= eof_strobe & v.rx_end;
      addr_irq_pulse <= eof_strobe & v.addr_irq & filtered;
      if (eof_strobe) crc_ok_flag <= v.crc_ok;
    end
  end
endmodule

// File: rtl/rxack_turnaround.sv
module rxack_turnaround #(
  parameter int LONG_SYMS  = 12,
  parameter int SHORT_SYMS = 2,
  localparam int CNT_W = $clog2(LONG_SYMS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic eof_strobe,
  input  logic ack_go,
  input  logic short_sel,
  input  logic sym_tick,
  output logic ack_start_pulse
);
  localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_SYMS);
  localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_SYMS);

  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx = cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed           <= 1'b0;
      cnt             <= '0;
      target          <= LONG_C;
      ack_start_pulse <= 1'b0;
    end else begin
      ack_start_pulse <= 1'b0;
      if (eof_strobe) begin
        armed  <= ack_go;
        cnt    <= '0;
        target <= short_sel ? SHORT_C : LONG_C;
      end else if (armed && sym_tick) begin
        if (cnt_nx == target) begin
          armed           <= 1'b0;
          cnt             <= '0;
          ack_start_pulse <= 1'b1;
        end else begin
          cnt <= cnt_nx;
        end
      end
    end
  end
endmodule

// File: rtl/rxack_filter_top.sv
module rxack_filter_top
  import rxack_pkg::*;
#(
  parameter int TYPE_W     = FT_W,
  parameter int LONG_SYMS  = 12,
  parameter int SHORT_SYMS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sym_tick,
  input  logic              eof_strobe,
  input  logic              phr_ok,
  input  logic [TYPE_W-1:0] frame_type,
  input  logic              ack_req,
  input  logic              addr_hit,
  input  logic              fcs_ok,
  input  logic              cfg_filt_rsv,
  input  logic              cfg_upld_rsv,
  input  logic              cfg_short_ack,
  input  logic              cfg_promisc,
  input  logic              cfg_no_ack,
  output logic              rx_end_pulse,
  output logic              addr_irq_pulse,
  output logic              crc_ok_flag,
  output logic              ack_start_pulse
);
  frm_class_e cls;
  logic       ack_go;

  rxack_class #(.TYPE_W(TYPE_W)) u_class (
    .frame_type (frame_type),
    .filt_rsv   (cfg_filt_rsv),
    .upld_rsv   (cfg_upld_rsv),
    .cls        (cls)
  );

  rxack_verdict u_verdict (
    .clk            (clk),
    .rst            (rst),
    .eof_strobe     (eof_strobe),
    .phr_ok         (phr_ok),
    .ack_req        (ack_req),
    .addr_hit       (addr_hit),
    .fcs_ok         (fcs_ok),
    .cls            (cls),
    .promisc        (cfg_promisc),
    .no_ack         (cfg_no_ack),
    .rx_end_pulse   (rx_end_pulse),
    .addr_irq_pulse (addr_irq_pulse),
    .crc_ok_flag    (crc_ok_flag),
    .ack_go         (ack_go)
  );

  rxack_turnaround #(.LONG_SYMS(LONG_SYMS), .SHORT_SYMS(SHORT_SYMS)) u_turn (
    .clk             (clk),
    .rst             (rst),
    .eof_strobe      (eof_strobe),
    .ack_go          (ack_go),
    .short_sel       (cfg_short_ack),
    .sym_tick        (sym_tick),
    .ack_start_pulse (ack_start_pulse)
  );
endmodule

// File: rtl/rxack_chk.sv
module rxack_chk #(
  parameter int LONG_SYMS  = 12,
  parameter int SHORT_SYMS = 2,
  localparam int CW = $clog2(LONG_SYMS + 2)
) (
  input logic clk,
  input logic rst,
  input logic sym_tick,
  input logic eof_strobe,
  input logic phr_ok,
  input logic fcs_ok,
  input logic cfg_short_ack,
  input logic cfg_promisc,
  input logic cfg_no_ack,
  input logic rx_end_pulse,
  input logic addr_irq_pulse,
  input logic crc_ok_flag,
  input logic ack_start_pulse
);
  logic [CW-1:0] ticks;
  logic          short_q;
  logic          noack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ticks   <= '0;
      short_q <= 1'b0;
      noack_q <= 1'b0;
    end else if (eof_strobe) begin
      ticks   <= '0;
      short_q <= cfg_short_ack;
      noack_q <= cfg_no_ack;
    end else if (sym_tick && ticks != {CW{1'b1}}) begin
      ticks <= ticks + CW'(1);
    end
  end

  // R4
  rx_end_after_eof_chk: assert property (@(posedge clk) disable iff (rst)
    rx_end_pulse |-> $past(eof_strobe));
  // R4
  addr_irq_after_eof_chk: assert property (@(posedge clk) disable iff (rst)
    addr_irq_pulse |-> $past(eof_strobe && phr_ok));
  // R8
  promisc_reports_chk: assert property (@(posedge clk) disable iff (rst)
    (eof_strobe && phr_ok && cfg_promisc) |=> rx_end_pulse);
  // R9
  crc_update_chk: assert property (@(posedge clk) disable iff (rst)
    eof_strobe |=> (crc_ok_flag == $past(phr_ok && fcs_ok)));
  // R9
  crc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !eof_strobe |=> $stable(crc_ok_flag));
  // R10
  no_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ack_start_pulse |-> !noack_q);
  // R6
  ack_window_chk: assert property (@(posedge clk) disable iff (rst)
    ack_start_pulse |-> (ticks == CW'(short_q ? SHORT_SYMS : LONG_SYMS)));
  // R11
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    ack_start_pulse |=> !ack_start_pulse);
endmodule

bind rxack_filter_top rxack_chk #(.LONG_SYMS(LONG_SYMS), .SHORT_SYMS(SHORT_SYMS)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .sym_tick        (sym_tick),
  .eof_strobe      (eof_strobe),
  .phr_ok          (phr_ok),
  .fcs_ok          (fcs_ok),
  .cfg_short_ack   (cfg_short_ack),
  .cfg_promisc     (cfg_promisc),
  .cfg_no_ack      (cfg_no_ack),
  .rx_end_pulse    (rx_end_pulse),
  .addr_irq_pulse  (addr_irq_pulse),
  .crc_ok_flag     (crc_ok_flag),
  .ack_start_pulse (ack_start_pulse)
);

// File: tb/rxack_filter_top_tb.sv
module rxack_filter_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sym_tick = 1'b0, eof_strobe = 1'b0, phr_ok = 1'b0;
  logic [2:0] frame_type = 3'd0;
  logic ack_req = 1'b0, addr_hit = 1'b0, fcs_ok = 1'b0;
  logic cfg_filt_rsv = 1'b0, cfg_upld_rsv = 1'b0, cfg_short_ack = 1'b0;
  logic cfg_promisc = 1'b0, cfg_no_ack = 1'b0;
  logic rx_end_pulse, addr_irq_pulse, crc_ok_flag, ack_start_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  rxack_filter_top u_dut (
    .clk(clk), .rst(rst), .sym_tick(sym_tick), .eof_strobe(eof_strobe),
    .phr_ok(phr_ok), .frame_type(frame_type), .ack_req(ack_req),
    .addr_hit(addr_hit), .fcs_ok(fcs_ok), .cfg_filt_rsv(cfg_filt_rsv),
    .cfg_upld_rsv(cfg_upld_rsv), .cfg_short_ack(cfg_short_ack),
    .cfg_promisc(cfg_promisc), .cfg_no_ack(cfg_no_ack),
    .rx_end_pulse(rx_end_pulse), .addr_irq_pulse(addr_irq_pulse),
    .crc_ok_flag(crc_ok_flag), .ack_start_pulse(ack_start_pulse)
  );

  typedef struct {
    bit    rx_end;
    bit    addr;
    bit    crc;
    bit    ack;
    int    dly;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: one frame, then ticks_after symbol ticks before returning
  task automatic send(input bit phr, input logic [2:0] ft, input bit req, input bit hit,
                      input bit fcs, input bit filt, input bit upld, input bit shrt,
                      input bit prom, input bit noack, input int ticks_after,
                      input string tag);
    exp_t e;
    bit rsv, as_data, ackable;
    rsv     = ft[2];
    as_data = !rsv || (upld && filt);
    ackable = (ft == 3'b001) || (ft == 3'b011) || (rsv && upld && filt);
    e.tag = tag;
    e.crc = phr && fcs;
    e.dly = shrt ? 2 : 12;
    if (!phr) begin
      e.rx_end = 0; e.addr = 0; e.ack = 0;
    end else begin
      e.addr   = as_data && hit;
      e.rx_end = prom ? 1'b1 : (as_data ? (hit && fcs) : (upld && fcs));
      e.ack    = ackable && as_data && hit && fcs && req && !noack && (ticks_after >= e.dly);
    end
    @(posedge clk); #1;
    phr_ok = phr; frame_type = ft; ack_req = req; addr_hit = hit; fcs_ok = fcs;
    cfg_filt_rsv = filt; cfg_upld_rsv = upld; cfg_short_ack = shrt;
    cfg_promisc = prom; cfg_no_ack = noack; eof_strobe = 1'b1;
    exp_q.push_back(e);
    @(posedge clk); #1;
    eof_strobe = 1'b0;
    // R12: configuration changes after the strobe must not matter
    cfg_short_ack = ~shrt; cfg_no_ack = ~noack; cfg_promisc = ~prom;
    cfg_filt_rsv = ~filt; cfg_upld_rsv = ~upld;
    for (int i = 0; i < ticks_after; i++) begin
      repeat (2) @(posedge clk);
      #1 sym_tick = 1'b1;
      @(posedge clk); #1 sym_tick = 1'b0;
    end
    repeat (3) @(posedge clk);
  endtask

  // Monitor / scoreboard
  exp_t cur;
  bit   cur_valid = 0;
  bit   ack_seen  = 0;
  int   ticks     = 0;
  bit   eof_prev  = 0;

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (eof_prev) begin
        if (cur_valid)
          check(ack_seen == cur.ack, {cur.tag, " ack presence"}, ack_seen, cur.ack);
        if (exp_q.size() == 0) begin
          check(0, "scoreboard empty", 0, 1);
          cur_valid = 0;
        end else begin
          cur = exp_q.pop_front();
          cur_valid = 1;
          check(rx_end_pulse == cur.rx_end, {cur.tag, " rx_end"}, rx_end_pulse, cur.rx_end);
          check(addr_irq_pulse == cur.addr, {cur.tag, " addr_irq"}, addr_irq_pulse, cur.addr);
          check(crc_ok_flag == cur.crc, {cur.tag, " R9 crc flag"}, crc_ok_flag, cur.crc);
        end
        ack_seen = 0;
        ticks = 0;
      end else if (rx_end_pulse || addr_irq_pulse) begin
        check(0, "R4 stray pulse", 1, 0);
      end
      if (ack_start_pulse) begin
        if (!cur_valid || !cur.ack || ack_seen)
          check(0, {cur.tag, " unexpected ack_start"}, 1, 0);
        else
          check(ticks == cur.dly, {cur.tag, " R6 R7 turnaround ticks"}, ticks, cur.dly);
        ack_seen = 1;
      end
      eof_prev = eof_strobe;
      if (sym_tick && !eof_strobe) ticks++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    check(rx_end_pulse == 0, "R13 reset rx_end", rx_end_pulse, 0);
    check(addr_irq_pulse == 0, "R13 reset addr_irq", addr_irq_pulse, 0);
    check(crc_ok_flag == 0, "R13 reset crc", crc_ok_flag, 0);
    check(ack_start_pulse == 0, "R13 reset ack", ack_start_pulse, 0);

    //    phr ft    req hit fcs filt upld shrt prom noack ticks tag
    send(1, 3'b001, 1, 1, 1, 0, 0, 0, 0, 0, 14, "R6 R5 data long ack");
    send(1, 3'b011, 1, 1, 1, 0, 0, 1, 0, 0, 4,  "R7 R5 cmd short ack");
    send(1, 3'b001, 0, 1, 1, 0, 0, 1, 0, 0, 4,  "R5 no ack request");
    send(1, 3'b000, 1, 1, 1, 0, 0, 1, 0, 0, 4,  "R5 beacon not acked");
    send(1, 3'b010, 1, 1, 1, 0, 0, 1, 0, 0, 4,  "R5 ack type not acked");
    send(1, 3'b001, 1, 1, 0, 0, 0, 1, 0, 0, 4,  "R4 bad fcs");
    send(1, 3'b001, 1, 0, 1, 0, 0, 1, 0, 0, 4,  "R4 addr miss");
    send(1, 3'b001, 1, 1, 0, 0, 0, 1, 1, 0, 4,  "R8 promisc bad fcs");
    send(1, 3'b011, 1, 0, 1, 0, 0, 1, 1, 0, 4,  "R8 promisc addr miss");
    send(1, 3'b001, 1, 1, 1, 0, 0, 1, 1, 0, 4,  "R8 promisc passing acked");
    send(1, 3'b001, 1, 1, 1, 0, 0, 1, 0, 1, 4,  "R10 disable ack");
    send(1, 3'b101, 1, 1, 1, 1, 0, 1, 0, 0, 4,  "R1 reserved dropped");
    send(1, 3'b110, 1, 1, 1, 0, 0, 1, 1, 0, 4,  "R1 R8 reserved promisc");
    send(1, 3'b100, 1, 1, 1, 0, 1, 1, 0, 0, 4,  "R2 reserved fcs ok");
    send(1, 3'b111, 1, 1, 0, 0, 1, 1, 0, 0, 4,  "R2 reserved fcs bad");
    send(1, 3'b100, 1, 1, 1, 1, 1, 1, 0, 0, 4,  "R3 reserved as data");
    send(1, 3'b111, 1, 0, 1, 1, 1, 0, 0, 0, 14, "R3 reserved as data miss");
    send(0, 3'b001, 1, 1, 1, 0, 0, 1, 1, 0, 4,  "R13 phr invalid");
    send(1, 3'b001, 1, 1, 1, 0, 0, 0, 0, 0, 5,  "R11 cancelled ack");
    send(1, 3'b011, 1, 1, 1, 0, 0, 0, 0, 0, 13, "R12 R6 long after cancel");
    send(1, 3'b001, 1, 1, 1, 0, 0, 1, 0, 0, 1,  "R11 short cancelled");
    // flush frame closes the previous window
    send(0, 3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 1,  "R13 flush");
    repeat (4) @(posedge clk);
    if (!done) begin
      done = 1;
      check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule